// File: doc/BRIEF.md
# Interrupt acknowledge and end-of-interrupt interface

This unit connects one processor to the interrupt distributor. Each cycle the distributor offers a single best candidate: a source ID, an 8-bit priority and, for software-generated sources, the number of the CPU that raised it. The unit decides whether that candidate may interrupt the processor. It checks four things: the enable, a programmable priority mask, the priority of the interrupt now being serviced, and the room left for nesting. If the candidate passes, the unit drives the interrupt line.

The processor talks to the unit through a small register port with four word addresses:

| Address | Register | Access |
|---|---|---|
| 0 | enable control | read/write |
| 1 | priority mask | read/write |
| 2 | acknowledge | read |
| 3 | end-of-interrupt | write |

Reading the acknowledge word claims the winner. The unit pulses its ID back to the distributor so that the distributor can clear the pending bit and mark the source active. Claimed interrupts are kept on a stack of nested running priorities. Writing the ID of the most recently claimed interrupt to the end-of-interrupt word retires it, pops the stack and informs the distributor.

A lower priority value means a more urgent interrupt. An empty stack runs at the idle priority 0xFF.

Top module: `cif_ack_eoi`

## Requirements
- R1: After reset the enable is 0, the mask reads 0x00, no interrupt is active, and `irq_o`, `rvalid_o`, `ack_o` and `eoi_o` are low.
- R2: While enable bit 0 (address 0) is clear, `irq_o` stays low and an acknowledge read returns 1023.
- R3: `irq_o` is high only when the candidate's priority is strictly below the mask byte (address 1). For example, a mask of 0xF0 admits 0xA0, but a mask equal to the candidate's priority blocks it.
- R4: `irq_o` is high only when the candidate's priority is strictly below the running priority. The running priority is that of the most recently claimed, unretired interrupt, or 0xFF when none is active.
- R5: An acknowledge read (address 2) of an eligible candidate has these effects:
  - Bits [9:0] of the returned word hold the candidate ID.
  - `ack_o` pulses for one cycle, with that ID on `ack_id_o`, together with `rvalid_o`.
  - The candidate's priority becomes the running priority.
- R6: An acknowledge read with no eligible candidate returns 1023 and has no side effects: no `ack_o` pulse and no change of running priority.
- R7: For IDs 0-15 the acknowledge word carries the requesting CPU number in bits [12:10]. For other IDs those bits are zero.
- R8: An end-of-interrupt write (address 3) whose bits [9:0] equal the most recently claimed active ID retires that interrupt. `eoi_o` pulses with the ID on `eoi_id_o` one cycle later, and the running priority returns to that of the previous active interrupt, or to 0xFF.
- R9: An end-of-interrupt write whose ID does not match the most recently claimed active interrupt is ignored. There is no `eoi_o` pulse and the running priority is unchanged.
- R10: Candidate IDs 1020-1023 are reserved and never signalled or claimed; ID 1019 is.
- R11: When `NEST_DEPTH` interrupts are active, `irq_o` stays low and an acknowledge read returns 1023.
- R12: Reads of address 0 return the enable in bit 0. Reads of address 1 return the mask in bits [7:0]. Read data appears on `rdata_o` with `rvalid_o` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate source ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_cpu_i | input | CPU_W | Requesting CPU for software-generated IDs |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register word address |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_o | output | 1 | Claim pulse to the distributor |
| ack_id_o | output | 10 | Claimed ID |
| eoi_o | output | 1 | Retire pulse to the distributor |
| eoi_id_o | output | 10 | Retired ID |

## Verification
An acknowledge read and a change of the distributor's candidate can fall in the same cycle. The claim must then use the candidate present at that clock edge, and `irq_o` must be re-evaluated against the raised running priority in the next cycle. The bench provokes this by switching the candidate ID, priority and CPU number at the same instant it issues the read. It judges the result by the returned word, the claim pulse and the following `irq_o`, each computed from a queue-based model of the active interrupts.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int ID_W       = 10;
  localparam int PRIO_W     = 8;
  localparam int DATA_W     = 32;
  localparam int CPU_LSB    = 10;
  localparam int SGI_LIMIT  = 16;

  localparam logic [ID_W-1:0]   ID_SPURIOUS = 10'd1023;
  localparam logic [ID_W-1:0]   ID_RSVD_LO  = 10'd1020;
  localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_PMASK = 2'd1,
    REG_ACK   = 2'd2,
    REG_EOI   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [PRIO_W-1:0] prio;
  } act_ent_t;
endpackage

// File: rtl/cif_cfg_regs.sv
module cif_cfg_regs
  import cif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_pmask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] pmask_o
);
  logic [DATA_W-1:PRIO_W] unused_wdata;
  assign unused_wdata = wdata_i[DATA_W-1:PRIO_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      pmask_o <= '0;
    end else begin
      if (wr_ctrl_i)  en_o    <= wdata_i[0];
      if (wr_pmask_i) pmask_o <= wdata_i[PRIO_W-1:0];
    end
  end
endmodule

// File: rtl/cif_gate.sv
module cif_gate
  import cif_pkg::*;
(
  input  logic              en_i,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] pmask_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  input  logic              full_i,
  output logic              elig_o
);
  logic id_ok, beats_mask, beats_run;

  always_comb begin
    id_ok      = cand_id_i < ID_RSVD_LO;
    beats_mask = cand_prio_i < pmask_i;
    beats_run  = cand_prio_i < run_prio_i;
    elig_o     = en_i && cand_valid_i && id_ok && beats_mask && beats_run && !full_i;
  end
endmodule

// File: rtl/cif_act_stack.sv
module cif_act_stack
  import cif_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  act_ent_t          push_ent_i,
  input  logic              pop_req_i,
  input  logic [ID_W-1:0]   pop_id_i,
  output logic              match_o,
  output logic [PRIO_W-1:0] top_prio_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              full_o
);
  act_ent_t        ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx, wr_idx;

  always_comb begin
    top_idx    = IDX_W'(cnt_q - 1'b1);
    wr_idx     = IDX_W'(cnt_q);
    full_o     = cnt_q == CNT_W'(DEPTH);
    match_o    = (cnt_q != '0) && (ent_q[top_idx].id == pop_id_i);
    top_prio_o = (cnt_q == '0) ? PRIO_IDLE : ent_q[top_idx].prio;
    depth_o    = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i && !full_o) begin
      ent_q[wr_idx] <= push_ent_i;
      cnt_q         <= cnt_q + 1'b1;
    end else if (pop_req_i && match_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cif_ack_eoi.sv
module cif_ack_eoi
  import cif_pkg::*;
#(
  parameter int NEST_DEPTH = 4,
  parameter int CPU_W      = 3,
  localparam int CNT_W     = $clog2(NEST_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [CPU_W-1:0]  cand_cpu_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              ack_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  reg_sel_e          sel;
  logic              rd, wr, ack_rd, take, eoi_wr, match, retire, en, full, elig;
  logic [PRIO_W-1:0] pmask, run_prio;
  logic [CNT_W-1:0]  depth;
  logic [DATA_W-1:0] ack_word, rd_next;
  act_ent_t          new_ent;

  assign sel    = reg_sel_e'(addr_i);
  assign rd     = req_i && !we_i;
  assign wr     = req_i && we_i;
  assign ack_rd = rd && (sel == REG_ACK);
  assign eoi_wr = wr && (sel == REG_EOI);
  assign take   = ack_rd && elig;
  assign retire = eoi_wr && match;

  cif_cfg_regs u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ctrl_i  (wr && (sel == REG_CTRL)),
    .wr_pmask_i (wr && (sel == REG_PMASK)),
    .wdata_i    (wdata_i),
    .en_o       (en),
    .pmask_o    (pmask)
  );

  cif_gate u_gate (
    .en_i         (en),
    .cand_valid_i (cand_valid_i),
    .cand_id_i    (cand_id_i),
    .cand_prio_i  (cand_prio_i),
    .pmask_i      (pmask),
    .run_prio_i   (run_prio),
    .full_i       (full),
    .elig_o       (elig)
  );

  assign new_ent = '{id: cand_id_i, prio: cand_prio_i};

  cif_act_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_ent_i (new_ent),
    .pop_req_i  (eoi_wr),
    .pop_id_i   (wdata_i[ID_W-1:0]),
    .match_o    (match),
    .top_prio_o (run_prio),
    .depth_o    (depth),
    .full_o     (full)
  );

  assign irq_o = elig;

  // software-generated IDs carry the source CPU above the ID field
  always_comb begin
    ack_word = DATA_W'(cand_id_i);
    if (cand_id_i < ID_W'(SGI_LIMIT))
      ack_word[CPU_LSB +: CPU_W] = cand_cpu_i;
  end

  always_comb begin
    unique case (sel)
      REG_CTRL:  rd_next = DATA_W'(en);
      REG_PMASK: rd_next = DATA_W'(pmask);
      REG_ACK:   rd_next = take ? ack_word : DATA_W'(ID_SPURIOUS);
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
      ack_o    <= 1'b0;
      ack_id_o <= '0;
      eoi_o    <= 1'b0;
      eoi_id_o <= '0;
    end else begin
      rvalid_o <= rd;
      ack_o    <= take;
      eoi_o    <= retire;
      if (rd)     rdata_o  <= rd_next;
      if (take)   ack_id_o <= cand_id_i;
      if (retire) eoi_id_o <= wdata_i[ID_W-1:0];
    end
  end
endmodule

// File: rtl/cif_ack_eoi_chk.sv
module cif_ack_eoi_chk
  import cif_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PRIO_W-1:0] cand_prio_i,
  input logic              irq_o,
  input logic              ack_o,
  input logic [ID_W-1:0]   ack_id_o,
  input logic              rvalid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              eoi_o,
  input logic [PRIO_W-1:0] pmask_i,
  input logic [PRIO_W-1:0] run_prio_i,
  input logic [CNT_W-1:0]  depth_i
);
  p_irq_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cand_prio_i < pmask_i);

  p_irq_running_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cand_prio_i < run_prio_i);

  p_ack_push_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> rvalid_o && (rdata_o[ID_W-1:0] == ack_id_o) && (ack_id_o < ID_RSVD_LO));

  p_spurious_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && rdata_o[ID_W-1:0] == ID_SPURIOUS) |-> !ack_o);

  p_sgi_cpu_field_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && ack_id_o >= ID_W'(SGI_LIMIT)) |-> rdata_o[DATA_W-1:ID_W] == '0);

  p_eoi_pops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_o |-> depth_i == $past(depth_i) - 1'b1);

  p_depth_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_i <= CNT_W'(DEPTH));

  p_full_no_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_i == CNT_W'(DEPTH)) |-> !irq_o);
endmodule

bind cif_ack_eoi cif_ack_eoi_chk #(.DEPTH(NEST_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cand_prio_i (cand_prio_i),
  .irq_o       (irq_o),
  .ack_o       (ack_o),
  .ack_id_o    (ack_id_o),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .eoi_o       (eoi_o),
  .pmask_i     (pmask),
  .run_prio_i  (run_prio),
  .depth_i     (depth)
);

// File: tb/tb_cif_ack_eoi.sv
module tb_cif_ack_eoi;
  localparam int DEPTH = 4;
  localparam int CPU_W = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cand_valid_i = 1'b0;
  logic [9:0]  cand_id_i = '0;
  logic [7:0]  cand_prio_i = '0;
  logic [2:0]  cand_cpu_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        rvalid_o, irq_o, ack_o, eoi_o;
  logic [31:0] rdata_o;
  logic [9:0]  ack_id_o, eoi_id_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit          m_en = 0;
  int unsigned m_pmr = 0;
  int unsigned m_ids[$];
  int unsigned m_prs[$];

  always #10 clk_i = ~clk_i;

  cif_ack_eoi #(.NEST_DEPTH(DEPTH), .CPU_W(CPU_W)) dut (.*);

  function automatic bit m_elig();
    int unsigned run;
    run = (m_prs.size() == 0) ? 255 : m_prs[$];
    return m_en && cand_valid_i && (cand_id_i < 1020) && (cand_prio_i < m_pmr)
           && (cand_prio_i < run) && (m_ids.size() < DEPTH);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cand(input bit v, input int unsigned id, input int unsigned pr, input int unsigned cpu);
    cand_valid_i = v;
    cand_id_i    = 10'(id);
    cand_prio_i  = 8'(pr);
    cand_cpu_i   = 3'(cpu);
  endtask

  task automatic step(input string tag, input bit rq, input bit w, input logic [1:0] a, input logic [31:0] d);
    bit e_rv = 0, e_ack = 0, e_eoi = 0;
    logic [31:0] e_rd = 0;
    logic [9:0] e_aid = 0, e_eid = 0;
    req_i = rq; we_i = w; addr_i = a; wdata_i = d;
    if (rq && !w) begin
      e_rv = 1;
      case (a)
        2'd0: e_rd = 32'(m_en);
        2'd1: e_rd = m_pmr;
        2'd2: if (m_elig()) begin
                e_ack = 1; e_aid = cand_id_i;
                e_rd = 32'(cand_id_i) + ((cand_id_i < 16) ? (32'(cand_cpu_i) << 10) : 0);
                m_ids.push_back(cand_id_i); m_prs.push_back(cand_prio_i);
              end else e_rd = 1023;
        default: e_rd = 0;
      endcase
    end
    if (rq && w) begin
      case (a)
        2'd0: m_en = d[0];
        2'd1: m_pmr = d[7:0];
        2'd3: if (m_ids.size() > 0 && d[9:0] == m_ids[$]) begin
                e_eoi = 1; e_eid = d[9:0];
                void'(m_ids.pop_back()); void'(m_prs.pop_back());
              end
        default: ;
      endcase
    end
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    chk(tag, "rvalid", 32'(rvalid_o), 32'(e_rv));
    if (e_rv) chk(tag, "rdata", rdata_o, e_rd);
    chk(tag, "ack", 32'(ack_o), 32'(e_ack));
    if (e_ack) chk(tag, "ack_id", 32'(ack_id_o), 32'(e_aid));
    chk(tag, "eoi", 32'(eoi_o), 32'(e_eoi));
    if (e_eoi) chk(tag, "eoi_id", 32'(eoi_id_o), 32'(e_eid));
    chk(tag, "irq", 32'(irq_o), 32'(m_elig()));
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 2'd0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "irq", 32'(irq_o), 0);
    chk("R1", "rvalid", 32'(rvalid_o), 0);
    chk("R1", "ack", 32'(ack_o), 0);
    chk("R1", "eoi", 32'(eoi_o), 0);
    step("R1", 1, 0, 2'd0, 0);
    step("R1", 1, 0, 2'd1, 0);

    // R2 disabled: no signal, spurious ack
    cand(1, 40, 8'hA0, 0);
    step("R2", 1, 1, 2'd1, 32'hF0);
    idle("R2");
    step("R2", 1, 0, 2'd2, 0);

    // R12 readback, R3 mask
    step("R12", 1, 1, 2'd0, 32'h1);
    step("R12", 1, 0, 2'd0, 0);
    step("R12", 1, 0, 2'd1, 0);
    step("R3", 1, 1, 2'd1, 32'hA0);
    step("R3", 1, 1, 2'd1, 32'hF0);

    // R5 claim, R4 running priority
    step("R5", 1, 0, 2'd2, 0);
    idle("R4");
    cand(1, 20, 8'h80, 0);
    idle("R4");
    step("R5", 1, 0, 2'd2, 0);
    // R7 SGI with CPU field, candidate changes in the read cycle
    cand(1, 5, 8'h40, 6);
    step("R7", 1, 0, 2'd2, 0);

    // R9 mismatched EOI, R8 matching EOI
    step("R9", 1, 1, 2'd3, 32'd40);
    step("R9", 1, 1, 2'd3, 32'd20);
    step("R8", 1, 1, 2'd3, 32'd5);

    // R11 fill the nesting stack
    cand(1, 100, 8'h30, 0);
    step("R11", 1, 0, 2'd2, 0);
    cand(1, 101, 8'h20, 0);
    step("R11", 1, 0, 2'd2, 0);
    cand(1, 102, 8'h10, 0);
    idle("R11");
    step("R11", 1, 0, 2'd2, 0);
    step("R8", 1, 1, 2'd3, 32'd101);
    step("R8", 1, 1, 2'd3, 32'd100);
    step("R8", 1, 1, 2'd3, 32'd20);
    step("R8", 1, 1, 2'd3, 32'd40);
    step("R9", 1, 1, 2'd3, 32'd40);

    // R10 reserved IDs vs last valid ID
    cand(1, 1021, 8'h10, 0);
    idle("R10");
    step("R10", 1, 0, 2'd2, 0);
    cand(1, 1019, 8'h10, 0);
    idle("R10");
    step("R10", 1, 0, 2'd2, 0);

    // R6 nothing offered
    cand(0, 33, 8'h00, 0);
    step("R6", 1, 0, 2'd2, 0);
    step("R8", 1, 1, 2'd3, 32'd1019);

    // R7 non-SGI ID keeps CPU bits clear; R2 disable with candidate pending
    cand(1, 16, 8'h50, 7);
    step("R7", 1, 0, 2'd2, 0);
    step("R8", 1, 1, 2'd3, 32'd16);
    step("R2", 1, 1, 2'd0, 32'h0);
    step("R2", 1, 0, 2'd2, 0);
    idle("R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule